// File: doc/BRIEF.md
# Serial EEPROM Memory-Side Model with Status and Write Protection

This block is the memory side of a small serial EEPROM with a watchdog field, written as synthesizable RTL so that a host-side SPI master and a separate watchdog block can be verified against it. It holds a 512-byte array and an 8-bit status register. It answers the six standard serial-EEPROM instructions in SPI mode 0: read, write, write-enable, write-disable, read status and write status.

All SPI pins are sampled by the system clock through a synchronizer. SCK must therefore run well below the system clock. Array and status writes are gated by several conditions:

- a write-enable latch, which is cleared by every completed nonvolatile write;
- a two-bit block-protect window held in the status register;
- an active-low write-protect pin.

A completed write holds the write-in-progress bit for a programmable number of clocks. While that bit is set, only the status read instruction is executed. The two watchdog bits of the status register are driven out to the watchdog block.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the status register reads 0x00 and `wdt_period_o` is 2'b00.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is status bit 1. Status bits 7:6 read 0.
- R3: A write (0x02) or status write (0x01) issued while the latch is clear changes neither the array nor the status register.
- R4: A status write updates only bits 5:4 (the watchdog period, driven on `wdt_period_o`) and bits 3:2 (block protect), taken from the first data byte.
- R5: A read (0x03) returns bytes MSB first from the given address and auto-increments, wrapping from 0x1FF to 0x000. Bit 3 of the read or write opcode is address bit 8, and the byte after the opcode gives bits 7:0.
- R6: Write data bytes fill the 4-byte page of the start address, wrapping the two low address bits. A later byte at the same location replaces an earlier one.
- R7: A valid write or status write sets status bit 0 for WIP_CYCLES clocks after CS rises and clears the latch. While bit 0 is set, only opcode 0x05 (status read) is executed.
- R8: Block protect 01 locks 0x180-0x1FF, 10 locks 0x100-0x1FF, 11 locks all, and 00 locks nothing. A write to a locked page leaves the array unchanged, starts no write cycle and keeps the latch set.
- R9: If `wp_n_i` is low when CS rises, no array or status write takes effect and the latch stays set.
- R10: A write frame whose CS rises after a partial data byte is discarded, and the latch stays set.
- R11: SPI mode 0: MOSI is sampled on SCK rise, MISO changes after SCK fall, and MISO is 0 while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| spi_sck_i | input | 1 | SPI serial clock |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data into the block |
| wp_n_i | input | 1 | write protect, low blocks nonvolatile writes |
| spi_miso_o | output | 1 | SPI data out of the block |
| wdt_period_o | output | 2 | status bits 5:4, watchdog period select |

## Verification
The write-cycle countdown and the instruction decoder can act in the same cycle. An opcode byte may complete while the countdown is still running, and its decode must then see the busy state. The bench provokes this right after a page write: it issues a write-enable and a read while the busy bit is still set. It judges the result by the status value after the cycle ends, which must show the latch clear, and by the read returning zeros rather than the freshly written bytes. A protected or write-protected write, in contrast, must leave the decoder free at once, which the bench confirms with the status latch bit still set.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // instruction byte values (read/write carry address bit 8 in bit 3)
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_A8_MASK = 8'hF7;

    typedef enum logic [2:0] {
        PH_OPC,   // collecting opcode
        PH_ADDR,  // collecting low address byte
        PH_RD,    // streaming array data out
        PH_WR,    // collecting page data
        PH_SRW,   // collecting new status byte
        PH_SRR,   // streaming status out
        PH_SKIP   // frame ignored until CS rises
    } phase_e;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int          STAGES = 2,
    parameter int          W      = 4,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST;
                    else        chain_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eep_lane_mem.sv
module eep_lane_mem #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [7:0]       wr_data,
    input  logic [ROW_W-1:0] rd_row,
    output logic [7:0]       rd_data
);
    localparam int ROWS = 1 << ROW_W;

    logic [7:0] cells_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) cells_q[wr_row] <= wr_data;
    end

    assign rd_data = cells_q[rd_row];
endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
    parameter int ROW_W = 7
) (
    input  logic [1:0]       bp,
    input  logic [ROW_W-1:0] row,
    output logic             locked
);
    // 01: top quarter, 10: top half, 11: whole array, 00: open
    always_comb begin
        unique case (bp)
            2'b01:   locked = &row[ROW_W-1 -: 2];
            2'b10:   locked = row[ROW_W-1];
            2'b11:   locked = 1'b1;
            default: locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
    parameter int PAGE_BYTES  = 4,
    parameter int WIP_CYCLES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck_i,
    input  logic       spi_cs_n_i,
    input  logic       spi_mosi_i,
    input  logic       wp_n_i,
    output logic       spi_miso_o,
    output logic [1:0] wdt_period_o
);
    import eep_pkg::*;

    localparam int ADDR_W = 9;
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int ROW_W  = ADDR_W - PAGE_W;
    localparam int CNT_W  = $clog2(WIP_CYCLES + 1);

    typedef struct packed {
        phase_e                  phase;
        logic [2:0]              bit_cnt;
        logic [6:0]              sh_in;
        logic [7:0]              sh_out;
        logic                    a8;
        logic                    is_rd;
        logic [ADDR_W-1:0]       addr;
        logic [ROW_W-1:0]        prow;
        logic [PAGE_BYTES-1:0]   pmask;
        logic [PAGE_BYTES*8-1:0] pdata;
        logic [3:0]              sr_new;
        logic                    sr_got;
        logic                    wel;
        logic [1:0]              bp;
        logic [1:0]              wd;
        logic [CNT_W-1:0]        wip_cnt;
        logic                    sck_prev;
        logic                    cs_prev;
    } state_t;

    state_t s_d, s_q;

    // synchronized pins: {sck, cs_n, mosi, wp_n}
    logic [3:0] pins_s;
    logic       sck_s, cs_s, mosi_s, wp_s;

    eep_pin_sync #(
        .STAGES (SYNC_STAGES),
        .W      (4),
        .RST    (4'b0100)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck_i, spi_cs_n_i, spi_mosi_i, wp_n_i}),
        .q     (pins_s)
    );

    assign {sck_s, cs_s, mosi_s, wp_s} = pins_s;

    // page lanes of the array
    logic [PAGE_BYTES-1:0] lane_we;
    logic [7:0]            lane_rd [PAGE_BYTES];

    generate
        for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
            eep_lane_mem #(
                .ROW_W (ROW_W)
            ) i_lane (
                .clk     (clk),
                .we      (lane_we[l]),
                .wr_row  (s_q.prow),
                .wr_data (s_q.pdata[l*8 +: 8]),
                .rd_row  (s_q.addr[ADDR_W-1:PAGE_W]),
                .rd_data (lane_rd[l])
            );
        end
    endgenerate

    logic locked;

    eep_guard #(
        .ROW_W (ROW_W)
    ) i_guard (
        .bp     (s_q.bp),
        .row    (s_q.prow),
        .locked (locked)
    );

    logic              busy;
    logic              sck_rise, sck_fall, cs_rise;
    logic [7:0]        byte_in;
    logic [7:0]        status;
    logic [ADDR_W-1:0] full_addr;

    always_comb begin
        s_d      = s_q;
        lane_we  = '0;
        busy     = (s_q.wip_cnt != '0);
        sck_rise = sck_s & ~s_q.sck_prev;
        sck_fall = ~sck_s & s_q.sck_prev;
        cs_rise  = cs_s & ~s_q.cs_prev;
        byte_in  = {s_q.sh_in, mosi_s};
        status   = {2'b00, s_q.wd, s_q.bp, s_q.wel, busy};
        full_addr = {s_q.a8, byte_in};

        s_d.sck_prev = sck_s;
        s_d.cs_prev  = cs_s;

        if (busy) s_d.wip_cnt = s_q.wip_cnt - CNT_W'(1);

        // end of frame: commit a complete, permitted write
        if (cs_rise && s_q.bit_cnt == 3'd0 && wp_s) begin
            if (s_q.phase == PH_WR && (|s_q.pmask) && !locked) begin
                lane_we     = s_q.pmask;
                s_d.wel     = 1'b0;
                s_d.wip_cnt = CNT_W'(WIP_CYCLES);
            end
            if (s_q.phase == PH_SRW && s_q.sr_got) begin
                s_d.wd      = s_q.sr_new[3:2];
                s_d.bp      = s_q.sr_new[1:0];
                s_d.wel     = 1'b0;
                s_d.wip_cnt = CNT_W'(WIP_CYCLES);
            end
        end

        if (cs_s) begin
            s_d.phase   = PH_OPC;
            s_d.bit_cnt = 3'd0;
            s_d.sh_out  = 8'h00;
            s_d.pmask   = '0;
            s_d.sr_got  = 1'b0;
        end else begin
            if (sck_rise) begin
                s_d.sh_in   = byte_in[6:0];
                s_d.bit_cnt = s_q.bit_cnt + 3'd1;
                if (s_q.bit_cnt == 3'd7) begin
                    unique case (s_q.phase)
                        PH_OPC: begin
                            s_d.phase = PH_SKIP;
                            if ((byte_in & OP_A8_MASK) == OP_READ) begin
                                if (!busy) begin
                                    s_d.phase = PH_ADDR;
                                    s_d.is_rd = 1'b1;
                                    s_d.a8    = byte_in[3];
                                end
                            end else if ((byte_in & OP_A8_MASK) == OP_WRITE) begin
                                if (!busy && s_q.wel) begin
                                    s_d.phase = PH_ADDR;
                                    s_d.is_rd = 1'b0;
                                    s_d.a8    = byte_in[3];
                                end
                            end else if (byte_in == OP_WREN) begin
                                if (!busy) s_d.wel = 1'b1;
                            end else if (byte_in == OP_WRDI) begin
                                if (!busy) s_d.wel = 1'b0;
                            end else if (byte_in == OP_RDSR) begin
                                s_d.phase = PH_SRR;
                            end else if (byte_in == OP_WRSR) begin
                                if (!busy && s_q.wel) s_d.phase = PH_SRW;
                            end
                        end
                        PH_ADDR: begin
                            s_d.addr  = full_addr;
                            s_d.prow  = full_addr[ADDR_W-1:PAGE_W];
                            s_d.phase = s_q.is_rd ? PH_RD : PH_WR;
                        end
                        PH_WR: begin
                            for (int l = 0; l < PAGE_BYTES; l++) begin
                                if (s_q.addr[PAGE_W-1:0] == PAGE_W'(l)) begin
                                    s_d.pdata[l*8 +: 8] = byte_in;
                                    s_d.pmask[l]        = 1'b1;
                                end
                            end
                            s_d.addr[PAGE_W-1:0] = s_q.addr[PAGE_W-1:0] + PAGE_W'(1);
                        end
                        PH_SRW: begin
                            if (!s_q.sr_got) begin
                                s_d.sr_new = byte_in[5:2];
                                s_d.sr_got = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            if (sck_fall) begin
                if (s_q.bit_cnt == 3'd0) begin
                    unique case (s_q.phase)
                        PH_RD: begin
                            s_d.sh_out = lane_rd[s_q.addr[PAGE_W-1:0]];
                            s_d.addr   = s_q.addr + ADDR_W'(1);
                        end
                        PH_SRR:  s_d.sh_out = status;
                        default: s_d.sh_out = 8'h00;
                    endcase
                end else begin
                    s_d.sh_out = {s_q.sh_out[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign spi_miso_o   = s_q.sh_out[7];
    assign wdt_period_o = s_q.wd;

endmodule

// File: rtl/eep_spi_slave_chk.sv
module eep_spi_slave_chk #(
    parameter int CNT_W      = 7,
    parameter int ROW_W      = 7,
    parameter int PAGE_BYTES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wel,
    input logic [1:0]            bp,
    input logic [1:0]            wd,
    input logic [CNT_W-1:0]      wip_cnt,
    input logic [PAGE_BYTES-1:0] lane_we,
    input logic [ROW_W-1:0]      wr_row,
    input logic                  wp_ok
);
    logic in_window;
    assign in_window = (bp == 2'b11) ||
                       (bp == 2'b10 && wr_row[ROW_W-1]) ||
                       (bp == 2'b01 && wr_row[ROW_W-1] && wr_row[ROW_W-2]);

    // R7: array commit starts the busy countdown and drops the latch
    a_r7_commit_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> (!wel && wip_cnt != '0));

    // R7: busy countdown steps down by one each clock
    a_r7_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_cnt != '0) |=> (wip_cnt == $past(wip_cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

    // R9: no array write with the protect pin low
    a_r9_pin_gates_array: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> wp_ok);

    // R8: no array write inside the protect window
    a_r8_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> !in_window);

    // R4: status fields move only while the latch was set
    a_r4_status_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((bp != $past(bp)) || (wd != $past(wd))) |-> $past(wel));

endmodule

bind eep_spi_slave eep_spi_slave_chk #(
    .CNT_W      (CNT_W),
    .ROW_W      (ROW_W),
    .PAGE_BYTES (PAGE_BYTES)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wel     (s_q.wel),
    .bp      (s_q.bp),
    .wd      (s_q.wd),
    .wip_cnt (s_q.wip_cnt),
    .lane_we (lane_we),
    .wr_row  (s_q.prow),
    .wp_ok   (wp_s)
);

// File: tb/test_eep_spi_slave.sv
module test_eep_spi_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WIP        = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       wp_n = 1'b1;
    logic       miso;
    logic [1:0] wdt;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_spi_slave #(
        .PAGE_BYTES  (4),
        .WIP_CYCLES  (WIP),
        .SYNC_STAGES (2)
    ) i_eep_spi_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck_i    (sck),
        .spi_cs_n_i   (cs_n),
        .spi_mosi_i   (mosi),
        .wp_n_i       (wp_n),
        .spi_miso_o   (miso),
        .wdt_period_o (wdt)
    );

    // address (9 bits) and byte for the write/read-back table
    localparam logic [16:0] VEC [0:6] = '{
        {9'h02D, 8'hF0}, {9'h02D, 8'h0F}, {9'h0C8, 8'h55}, {9'h195, 8'h6B},
        {9'h1FF, 8'hA1}, {9'h000, 8'hB2}, {9'h17F, 8'h3C}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_hi();
        tick(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(2*HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] x;
        cs_lo(); xfer(op, x); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] x;
        cs_lo(); xfer(8'h05, x); xfer(8'h00, st); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v, input bit wait_wip);
        logic [7:0] x;
        cs_lo(); xfer(8'h01, x); xfer(v, x); cs_hi();
        if (wait_wip) tick(WIP + 20);
    endtask

    task automatic wr(input logic [8:0] a, input int n, input logic [39:0] d, input bit wait_wip);
        logic [7:0] x;
        cs_lo();
        xfer({4'b0000, a[8], 3'b010}, x);
        xfer(a[7:0], x);
        for (int i = 0; i < n; i++) xfer(d[39-8*i -: 8], x);
        cs_hi();
        if (wait_wip) tick(WIP + 20);
    endtask

    task automatic rd(input logic [8:0] a, input int n, output logic [39:0] q);
        logic [7:0] x;
        logic [7:0] b;
        q = '0;
        cs_lo();
        xfer({4'b0000, a[8], 3'b011}, x);
        xfer(a[7:0], x);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, b);
            q[39-8*i -: 8] = b;
        end
        cs_hi();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  st;
        logic [39:0] q;
        logic [7:0]  x;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk("R1 wdt after reset", {6'b0, wdt}, 8'h00);
        chk("R11 miso idle", {7'b0, miso}, 8'h00);
        rdsr(st);
        chk("R1 status after reset", st, 8'h00);

        // R2 latch set/clear
        cmd(8'h06);
        rdsr(st);
        chk("R2 latch set", st, 8'h02);
        cmd(8'h04);
        rdsr(st);
        chk("R2 latch cleared", st, 8'h00);

        // table walk: single-byte writes and read-back (R5 read, R7 latch drop)
        for (int v = 0; v < 7; v++) begin
            cmd(8'h06);
            wr(VEC[v][16:8], 1, {VEC[v][7:0], 32'h0}, 1'b1);
            rd(VEC[v][16:8], 1, q);
            chk("R5 table readback", q[39:32], VEC[v][7:0]);
            rdsr(st);
            chk("R7 latch dropped after write", st, 8'h00);
        end

        // R5 wrap past the top address
        rd(9'h1FF, 2, q);
        chk("R5 byte at 0x1FF", q[39:32], 8'hA1);
        chk("R5 wrap to 0x000", q[31:24], 8'hB2);

        // R3 writes without latch are ignored
        wr(9'h02D, 1, {8'h99, 32'h0}, 1'b1);
        rd(9'h02D, 1, q);
        chk("R3 write without latch", q[39:32], 8'h0F);
        wrsr(8'h3C, 1'b1);
        rdsr(st);
        chk("R3 status write without latch", st, 8'h00);

        // R6 page wrap, R7 busy window and decoder lockout
        cmd(8'h06);
        wr(9'h0C9, 5, {8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1'b0);
        rdsr(st);
        chk("R7 busy bit set, latch clear", st, 8'h01);
        cmd(8'h06);
        rd(9'h0C8, 1, q);
        chk("R7 read ignored while busy", q[39:32], 8'h00);
        tick(WIP + 20);
        rdsr(st);
        chk("R7 enable ignored while busy", st, 8'h00);
        rd(9'h0C8, 4, q);
        chk("R6 page lane 0", q[39:32], 8'h44);
        chk("R6 page lane 1", q[31:24], 8'h55);
        chk("R6 page lane 2", q[23:16], 8'h22);
        chk("R6 page lane 3", q[15:8],  8'h33);

        // R4 status fields
        cmd(8'h06);
        wrsr(8'hFF, 1'b1);
        rdsr(st);
        chk("R4 only fields taken", st, 8'h3C);
        chk("R4 wdt period 3", {6'b0, wdt}, 8'h03);
        cmd(8'h06);
        wrsr(8'h24, 1'b1);
        rdsr(st);
        chk("R4 status 0x24", st, 8'h24);
        chk("R4 wdt period 2", {6'b0, wdt}, 8'h02);

        // R8 top quarter locked
        cmd(8'h06);
        wr(9'h195, 1, {8'h94, 32'h0}, 1'b1);
        rd(9'h195, 1, q);
        chk("R8 locked quarter kept", q[39:32], 8'h6B);
        rdsr(st);
        chk("R8 latch kept after locked write", st, 8'h26);
        wr(9'h17F, 1, {8'h77, 32'h0}, 1'b1);
        rd(9'h17F, 1, q);
        chk("R8 below quarter written", q[39:32], 8'h77);

        // R8 top half locked
        cmd(8'h06);
        wrsr(8'h08, 1'b1);
        rdsr(st);
        chk("R8 status bp=10", st, 8'h08);
        cmd(8'h06);
        wr(9'h17F, 1, {8'h12, 32'h0}, 1'b1);
        rd(9'h17F, 1, q);
        chk("R8 upper half kept", q[39:32], 8'h77);
        wr(9'h02D, 1, {8'h5E, 32'h0}, 1'b1);
        rd(9'h02D, 1, q);
        chk("R8 lower half open", q[39:32], 8'h5E);

        // R9 write-protect pin
        cmd(8'h06);
        wrsr(8'h00, 1'b1);
        rdsr(st);
        chk("R9 status cleared", st, 8'h00);
        wp_n = 1'b0;
        cmd(8'h06);
        wr(9'h02D, 1, {8'h99, 32'h0}, 1'b1);
        rd(9'h02D, 1, q);
        chk("R9 pin low blocks array", q[39:32], 8'h5E);
        wrsr(8'h30, 1'b1);
        rdsr(st);
        chk("R9 pin low blocks status", st, 8'h02);
        chk("R9 wdt unchanged", {6'b0, wdt}, 8'h00);
        wp_n = 1'b1;
        tick(4);

        // R10 partial data byte discarded
        cs_lo();
        xfer(8'h02, x);
        xfer(8'h2D, x);
        for (int i = 7; i >= 3; i--) begin
            mosi = 1'b1;
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        cs_hi();
        tick(WIP + 20);
        rd(9'h02D, 1, q);
        chk("R10 partial byte discarded", q[39:32], 8'h5E);
        rdsr(st);
        chk("R10 latch kept", st, 8'h02);
        chk("R11 miso low with CS high", {7'b0, miso}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule